// File: doc/BRIEF.md
# Keyword Stream Scanner

The block watches a byte stream and spots every occurrence of any keyword from a fixed set, taking one byte per clock and never stepping back over input already seen. The keyword automaton lives in an internal transition table addressed by the pair (current state, incoming byte). Each table cell carries the next state, a hit flag, a keyword number and a flag saying that further, shorter keywords also end on this byte. The host builds the automaton from its keywords and folds every fallback path into direct next-state values before it writes the table. It reloads the table whenever the keyword set changes.

Scanning walks the table once per accepted byte. The hit report comes from the cell chosen by the state and the byte together, so a keyword is flagged on the very transition that completes it. A start-of-stream marker sends the walk back to the root for that byte. A last-byte marker closes the stream. While a stream is open, the block locks out table writes so the automaton cannot change under a scan. A busy output shows when a stream is open.

Top module: `kw_scan_engine`

## Requirements
- R1: After reset the current state is the root (state 0), `busy` is 0 and `match_valid` is 0; a first byte sent without `in_sos` is looked up from the root.
- R2: Each byte accepted with `in_valid`=1 looks up the cell at (current state, `in_byte`), and the state register takes that cell's next-state field; with `in_valid`=0 the state is held, so gaps between bytes do not disturb a match in progress.
- R3: A byte accepted with `in_sos`=1 is looked up from the root state, whatever state the previous stream left behind.
- R4: When the cell used for an accepted byte has its hit flag set, `match_valid` is 1 in the cycle after that byte's clock edge and `match_id` carries the cell's keyword number; after a byte whose cell has no hit, and in any cycle after an edge where no byte was accepted, `match_valid` is 0.
- R5: `match_more` equals the cell's more flag and is only ever 1 together with `match_valid`. The host sets that flag when a byte completes more than one keyword, and gives the id of the longest of them.
- R6: `busy` becomes 1 after an accepted byte with `in_last`=0 and becomes 0 after an accepted byte with `in_last`=1; it is unchanged in cycles without an accepted byte.
- R7: A table write (`tbl_we`=1) is ignored when `busy` is 1 or when a byte is accepted in the same cycle; a byte accepted in the same cycle as an attempted write uses the old cell.
- R8: With keywords he=0, she=1, his=2, hers=3 loaded, the stream "ushers" reports id 1 with `match_more`=1 on the 'e' (fourth byte) and id 3 with `match_more`=0 on the final 's', and nothing on the other bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write request |
| tbl_state | input | STATE_W | State part of the cell address being written |
| tbl_byte | input | 8 | Byte part of the cell address being written |
| tbl_next | input | STATE_W | Next-state value to store |
| tbl_hit | input | 1 | Hit flag to store |
| tbl_more | input | 1 | More-keywords flag to store |
| tbl_id | input | ID_W | Keyword number to store |
| in_valid | input | 1 | A stream byte is presented this cycle |
| in_sos | input | 1 | This byte starts a new stream |
| in_last | input | 1 | This byte ends the stream |
| in_byte | input | 8 | Stream byte |
| match_valid | output | 1 | A keyword ended on the previous accepted byte |
| match_id | output | ID_W | Number of the longest keyword that ended |
| match_more | output | 1 | Further keywords ended on the same byte |
| busy | output | 1 | A stream is open; table writes are locked out |

## Verification
The bench derives its own automaton from the keyword strings by longest-suffix search. It loads it, then goes after the byte that closes two keywords at once. A design that dropped the more flag or reported the shorter keyword would show the wrong id there. It also starts a new stream in the middle of a partial match: a design that ignored the start marker would report "she" where nothing may match. Gaps between bytes catch a state register that advances without a byte. Writes attempted during an open stream, and in the same cycle as a byte, would change later matches if the lock were missing. The bench also checks that the concurrent byte uses the old cell.

// File: rtl/kws_pkg.sv
package kws_pkg;
  localparam int unsigned KWS_STATE_W = 4;
  localparam int unsigned KWS_SYM_W   = 8;
  localparam int unsigned KWS_ID_W    = 2;

  typedef enum logic {PH_IDLE = 1'b0, PH_SCAN = 1'b1} scan_phase_e;

  // width of one packed table cell: next state, hit, more, id
  function automatic int unsigned cell_bits(int unsigned sw, int unsigned iw);
    return sw + 2 + iw;
  endfunction

  // number of cells addressed by (state, symbol)
  function automatic int unsigned cell_count(int unsigned sw, int unsigned yw);
    return 1 << (sw + yw);
  endfunction
endpackage

// File: rtl/kws_table.sv
module kws_table #(
  parameter int unsigned STATE_W = kws_pkg::KWS_STATE_W,
  parameter int unsigned SYM_W   = kws_pkg::KWS_SYM_W,
  parameter int unsigned ID_W    = kws_pkg::KWS_ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic               wr_lock,
  input  logic [STATE_W-1:0] wr_state,
  input  logic [SYM_W-1:0]   wr_sym,
  input  logic [STATE_W-1:0] wr_next,
  input  logic               wr_hit,
  input  logic               wr_more,
  input  logic [ID_W-1:0]    wr_id,
  input  logic [STATE_W-1:0] rd_state,
  input  logic [SYM_W-1:0]   rd_sym,
  output logic [STATE_W-1:0] rd_next,
  output logic               rd_hit,
  output logic               rd_more,
  output logic [ID_W-1:0]    rd_id
);
  localparam int unsigned CELL_W = kws_pkg::cell_bits(STATE_W, ID_W);
  localparam int unsigned DEPTH  = kws_pkg::cell_count(STATE_W, SYM_W);
  localparam int unsigned ADDR_W = STATE_W + SYM_W;

  logic [CELL_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_take;
  logic [CELL_W-1:0] cell_at_wr;
  logic [CELL_W-1:0] rd_cell;

  assign wr_addr    = {wr_state, wr_sym};
  assign rd_addr    = {rd_state, rd_sym};
  assign wr_take    = wr_req && !wr_lock;
  assign cell_at_wr = cells[wr_addr];
  assign rd_cell    = cells[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_take) cells[wr_addr] <= {wr_next, wr_hit, wr_more, wr_id};
  end

  assign rd_next = rd_cell[CELL_W-1 -: STATE_W];
  assign rd_hit  = rd_cell[ID_W+1];
  assign rd_more = rd_cell[ID_W];
  assign rd_id   = rd_cell[ID_W-1:0];

  // R7: a locked write leaves the addressed cell as it was
  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_lock) |=> (cells[$past(wr_addr)] == $past(cell_at_wr)));
endmodule

// File: rtl/kws_walker.sv
module kws_walker #(
  parameter int unsigned STATE_W = kws_pkg::KWS_STATE_W,
  parameter int unsigned SYM_W   = kws_pkg::KWS_SYM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sos,
  input  logic               in_last,
  input  logic [STATE_W-1:0] tbl_next,
  output logic [STATE_W-1:0] look_state,
  output logic               step,
  output logic               busy
);
  import kws_pkg::*;
  localparam logic [STATE_W-1:0] ROOT = '0;

  logic [STATE_W-1:0] cur_state;
  scan_phase_e        phase;
  scan_phase_e        phase_nx;

  assign step       = in_valid;
  assign look_state = in_sos ? ROOT : cur_state;
  assign busy       = (phase == PH_SCAN);

  always_comb begin
    phase_nx = phase;
    if (step) phase_nx = in_last ? PH_IDLE : PH_SCAN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_state <= ROOT;
      phase     <= PH_IDLE;
    end else begin
      if (step) cur_state <= tbl_next;
      phase <= phase_nx;
    end
  end

  // R2: no accepted byte, no state change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cur_state));
  // R6: last byte closes the stream
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> !busy);
  // R6: any other accepted byte leaves the stream open
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |=> busy);
endmodule

// File: rtl/kws_report.sv
module kws_report #(
  parameter int unsigned ID_W = kws_pkg::KWS_ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            hit,
  input  logic            more,
  input  logic [ID_W-1:0] id,
  output logic            match_valid,
  output logic [ID_W-1:0] match_id,
  output logic            match_more
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      match_more  <= 1'b0;
      match_id    <= '0;
    end else begin
      match_valid <= step && hit;
      match_more  <= step && hit && more;
      if (step && hit) match_id <= id;
    end
  end

  // R4: a report only follows an accepted byte
  p_report_after_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(step));
  // R5: more flag never stands alone
  p_more_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_more |-> match_valid);
endmodule

// File: rtl/kw_scan_engine.sv
module kw_scan_engine #(
  parameter int unsigned STATE_W = kws_pkg::KWS_STATE_W,
  parameter int unsigned ID_W    = kws_pkg::KWS_ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [STATE_W-1:0] tbl_state,
  input  logic [7:0]         tbl_byte,
  input  logic [STATE_W-1:0] tbl_next,
  input  logic               tbl_hit,
  input  logic               tbl_more,
  input  logic [ID_W-1:0]    tbl_id,
  input  logic               in_valid,
  input  logic               in_sos,
  input  logic               in_last,
  input  logic [7:0]         in_byte,
  output logic               match_valid,
  output logic [ID_W-1:0]    match_id,
  output logic               match_more,
  output logic               busy
);
  localparam int unsigned SYM_W = 8;

  logic [STATE_W-1:0] look_state;
  logic [STATE_W-1:0] cell_next;
  logic               cell_hit;
  logic               cell_more;
  logic [ID_W-1:0]    cell_id;
  logic               step;
  logic               wr_lock;

  assign wr_lock = busy || in_valid;

  kws_table #(.STATE_W(STATE_W), .SYM_W(SYM_W), .ID_W(ID_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_req(tbl_we), .wr_lock(wr_lock),
    .wr_state(tbl_state), .wr_sym(tbl_byte),
    .wr_next(tbl_next), .wr_hit(tbl_hit), .wr_more(tbl_more), .wr_id(tbl_id),
    .rd_state(look_state), .rd_sym(in_byte),
    .rd_next(cell_next), .rd_hit(cell_hit), .rd_more(cell_more), .rd_id(cell_id)
  );

  kws_walker #(.STATE_W(STATE_W), .SYM_W(SYM_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sos(in_sos), .in_last(in_last),
    .tbl_next(cell_next), .look_state(look_state), .step(step), .busy(busy)
  );

  kws_report #(.ID_W(ID_W)) u_report (
    .clk(clk), .rst_n(rst_n),
    .step(step), .hit(cell_hit), .more(cell_more), .id(cell_id),
    .match_valid(match_valid), .match_id(match_id), .match_more(match_more)
  );
endmodule

// File: tb/kw_scan_engine_tb_top.sv
`timescale 1ns/1ps
module kw_scan_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_state = '0;
  logic [7:0] tbl_byte = '0;
  logic [3:0] tbl_next = '0;
  logic       tbl_hit = 1'b0;
  logic       tbl_more = 1'b0;
  logic [1:0] tbl_id = '0;
  logic       in_valid = 1'b0;
  logic       in_sos = 1'b0;
  logic       in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic       match_valid;
  logic [1:0] match_id;
  logic       match_more;
  logic       busy;

  always #4 clk = ~clk;

  kw_scan_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_state(tbl_state), .tbl_byte(tbl_byte),
    .tbl_next(tbl_next), .tbl_hit(tbl_hit), .tbl_more(tbl_more), .tbl_id(tbl_id),
    .in_valid(in_valid), .in_sos(in_sos), .in_last(in_last), .in_byte(in_byte),
    .match_valid(match_valid), .match_id(match_id), .match_more(match_more),
    .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench automaton, states named by the prefix they stand for
  string st_name [10] = '{"", "h", "he", "s", "sh", "she", "hi", "his", "her", "hers"};
  string kw_name [4]  = '{"he", "she", "his", "hers"};

  function automatic int find_state(string s);
    for (int i = 0; i < 10; i++) if (st_name[i] == s) return i;
    return -1;
  endfunction

  function automatic void model_step(input int cur, input logic [7:0] c,
                                     output int nxt, output bit hit,
                                     output bit more, output int id);
    string t;
    int cnt;
    int best;
    nxt = 0; hit = 0; more = 0; id = 0;
    if (c == 8'h00) return;
    t = $sformatf("%s%c", st_name[cur], c);
    for (int k = t.len(); k >= 1; k--) begin
      int j;
      j = find_state(t.substr(t.len() - k, t.len() - 1));
      if (j >= 0) begin nxt = j; break; end
    end
    cnt = 0; best = 0;
    for (int w = 0; w < 4; w++) begin
      int L;
      L = kw_name[w].len();
      if (L <= t.len() && t.substr(t.len() - L, t.len() - 1) == kw_name[w]) begin
        cnt++;
        if (L > best) begin best = L; id = w; end
      end
    end
    hit  = (cnt > 0);
    more = (cnt > 1);
  endfunction

  // scoreboard queues, one item per accepted byte
  int    q_hit[$];
  int    q_more[$];
  int    q_id[$];
  string q_req[$];
  int    m_state = 0;
  bit    acc = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) acc <= rst_n && in_valid;

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (acc) begin
        if (q_hit.size() == 0) begin
          chk(1'b0, "R4", "report with empty queue", int'(match_valid), 0);
        end else begin
          int eh, em, ei;
          string r;
          eh = q_hit.pop_front(); em = q_more.pop_front();
          ei = q_id.pop_front();  r  = q_req.pop_front();
          if (eh != 0) begin
            chk(match_valid == 1'b1, r, "match_valid", int'(match_valid), 1);
            chk(int'(match_id) == ei, r, "match_id", int'(match_id), ei);
            chk(int'(match_more) == em, r, "match_more", int'(match_more), em);
          end else begin
            chk(match_valid == 1'b0, r, "match_valid", int'(match_valid), 0);
            chk(match_more == 1'b0, r, "match_more", int'(match_more), 0);
          end
        end
      end else if (match_valid) begin
        chk(1'b0, "R4", "report without byte", 1, 0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_sos = 1'b0; in_last = 1'b0; tbl_we = 1'b0;
    end
  endtask

  task automatic wr_cell(input int s, input logic [7:0] b, input int nx,
                         input bit h, input bit mo, input int id, input bit with_byte);
    tbl_we = 1'b1; tbl_state = 4'(s); tbl_byte = b; tbl_next = 4'(nx);
    tbl_hit = h; tbl_more = mo; tbl_id = 2'(id);
    if (!with_byte) begin in_valid = 1'b0; in_sos = 1'b0; in_last = 1'b0; end
  endtask

  // driver: one byte, expected item pushed from the bench automaton
  task automatic send(input logic [7:0] c, input bit sos, input bit last,
                      input string req, input bit also_write);
    int nx, id;
    bit h, mo;
    @(negedge clk);
    if (sos) m_state = 0;
    model_step(m_state, c, nx, h, mo, id);
    m_state = nx;
    q_hit.push_back(int'(h)); q_more.push_back(int'(mo));
    q_id.push_back(id); q_req.push_back(req);
    in_valid = 1'b1; in_sos = sos; in_last = last; in_byte = c;
    if (!also_write) tbl_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(match_valid == 1'b0, "R1", "match_valid in reset", int'(match_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(match_valid == 1'b0, "R1", "match_valid after reset", int'(match_valid), 0);

    // load the automaton while idle
    for (int s = 0; s < 10; s++) begin
      for (int c = 0; c < 256; c++) begin
        int nx, id;
        bit h, mo;
        model_step(s, 8'(c), nx, h, mo, id);
        @(negedge clk);
        wr_cell(s, 8'(c), nx, h, mo, id, 1'b0);
      end
    end
    idle(2);

    // R1: first stream without a start marker walks from the root
    send("h", 1'b0, 1'b0, "R1", 1'b0);
    send("e", 1'b0, 1'b1, "R1", 1'b0);
    idle(2);

    // R8 / R5 / R6: ushers
    send("u", 1'b1, 1'b0, "R8", 1'b0);
    @(negedge clk);
    chk(busy == 1'b1, "R6", "busy after open byte", int'(busy), 1);
    in_valid = 1'b0;
    send("s", 1'b0, 1'b0, "R8", 1'b0);
    send("h", 1'b0, 1'b0, "R8", 1'b0);
    send("e", 1'b0, 1'b0, "R5", 1'b0);
    send("r", 1'b0, 1'b0, "R8", 1'b0);
    send("s", 1'b0, 1'b1, "R8", 1'b0);
    idle(1);
    chk(busy == 1'b0, "R6", "busy after last byte", int'(busy), 0);
    idle(2);

    // R2: gaps inside a stream
    send("h", 1'b1, 1'b0, "R2", 1'b0);
    idle(3);
    send("i", 1'b0, 1'b0, "R2", 1'b0);
    idle(2);
    chk(busy == 1'b1, "R6", "busy held over gap", int'(busy), 1);
    send("s", 1'b0, 1'b1, "R2", 1'b0);
    idle(2);

    // R3: start marker in the middle of a partial match
    send("s", 1'b1, 1'b0, "R3", 1'b0);
    send("h", 1'b0, 1'b0, "R3", 1'b0);
    send("e", 1'b1, 1'b1, "R3", 1'b0);
    idle(2);

    // R4: back-to-back keywords, overlap across them
    send("h", 1'b1, 1'b0, "R4", 1'b0);
    send("i", 1'b0, 1'b0, "R4", 1'b0);
    send("s", 1'b0, 1'b0, "R4", 1'b0);
    send("h", 1'b0, 1'b0, "R4", 1'b0);
    send("e", 1'b0, 1'b1, "R4", 1'b0);
    idle(2);

    // R7: write while a stream is open is ignored
    send("x", 1'b1, 1'b0, "R7", 1'b0);
    @(negedge clk);
    wr_cell(0, "h", 0, 1'b1, 1'b0, 2, 1'b0);
    @(negedge clk);
    wr_cell(1, "e", 0, 1'b0, 1'b0, 0, 1'b0);
    send("h", 1'b0, 1'b0, "R7", 1'b0);
    send("e", 1'b0, 1'b1, "R7", 1'b0);
    idle(2);

    // R7: write in the same cycle as a byte is ignored; byte sees old cell
    send("q", 1'b1, 1'b1, "R7", 1'b1);
    wr_cell(0, "q", 5, 1'b1, 1'b1, 3, 1'b1);
    idle(2);
    send("q", 1'b1, 1'b1, "R7", 1'b0);
    idle(2);
    send("h", 1'b1, 1'b0, "R7", 1'b0);
    send("e", 1'b0, 1'b1, "R7", 1'b0);
    idle(3);

    chk(q_hit.size() == 0, "R4", "queue drained", q_hit.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule